// File: doc/BRIEF.md
# Automatic Level Control Gain Loop

This block steers the gain code of an input amplifier so that the recorded signal peaks settle near a programmable target level. It watches a stream of signed audio samples that arrive with a sample strobe. It sorts the recent peak level into one of three zones: too loud, too quiet, or inside a narrow hysteresis band. It then moves a 6-bit gain code one step at a time. The code runs from 0 (-12 dB) to 63 (+35.25 dB), in 0.75 dB per step.

A loud signal pulls the gain down at once. A quiet signal raises the gain only after a programmable hold delay. The step rates for falling (attack) and rising (decay) come from 4-bit settings. Each setting step doubles the interval. A limiter mode swaps in faster base rates. All timing is counted in ticks, and each tick is a fixed number of master-clock cycles, so every time scales with the master clock. While the loop is disabled, the output follows a manual gain setting.

Top module: `alc_gain_loop`

## Requirements
- R1: The gain code is GAIN_W bits wide. Code 0 means -12 dB and each code step adds 0.75 dB. While the loop is enabled, the code changes by exactly one step per update.
- R2: While `en` is low, `gain_code` equals `cfg_manual_gain` and `gain_busy` is 0. Every timer and the peak window are cleared. When `en` rises, the loop starts from the manual value and times everything afresh from that cycle.
- R3: A sample whose magnitude exceeds the threshold thr(T) puts the loop in the loud zone on the next cycle. The threshold is full scale 2^(SAMPLE_W-1) times 10^((-28.5+1.5*T)/20), where T is the 4-bit `cfg_target` (0 gives -28.5 dBFS, 15 gives -6 dBFS). The magnitude of the most negative sample counts as 2^(SAMPLE_W-1).
- R4: The peak is checked once per window of PEAK_WIN strobed samples. A window whose largest magnitude is below thr - thr/8 marks the loop quiet. A window peak between that level and thr leaves the loop in the band zone.
- R5: In the loud zone the first decrement comes A ticks after the cycle in which the zone became loud, and further decrements follow every A ticks. No hold delay applies, whatever `cfg_hold` says.
- R6: In the quiet zone the first increment comes H + D ticks after the zone became quiet, and further increments follow every D ticks. H is 0 for a hold setting of 0, and HOLD_BASE << (h-1) for a setting h > 0.
- R7: D = decay base << `cfg_decay` and A = attack base << `cfg_attack`. Each tick lasts TICK_DIV clock cycles.
- R8: When `cfg_limiter` is 1, the limiter bases (DEC_STEP_LIM, ATK_STEP_LIM) replace the normal bases (DEC_STEP_ALC, ATK_STEP_ALC).
- R9: The gain code saturates at 0 and at 2^GAIN_W-1 and never wraps.
- R10: `gain_busy` is 1 only while a ramp is in progress: either loud with the gain above 0, or quiet with the hold elapsed and the gain below maximum.
- R11: In the band zone the gain code stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Loop enable; low selects manual gain |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | SAMPLE_W | Signed audio sample |
| cfg_target | input | 4 | Target level code, 1.5 dB per step from -28.5 dBFS |
| cfg_hold | input | 4 | Hold delay setting before gain rises |
| cfg_decay | input | 4 | Gain-rise interval setting |
| cfg_attack | input | 4 | Gain-fall interval setting |
| cfg_limiter | input | 1 | 1 selects the faster limiter rates |
| cfg_manual_gain | input | GAIN_W | Gain code used while disabled |
| gain_code | output | GAIN_W | Amplifier gain code |
| gain_busy | output | 1 | Gain ramp in progress |

## Verification
The hardest thing to reach from the ports is the exact start of the hold delay. The quiet zone is decided only at the end of a peak window, and the peak window runs freely against the samples. The stimulus therefore drops `en` before each case, which clears the window and all timers. It then re-enables the loop together with a constant-magnitude sample stream of alternating sign, so every event cycle can be worked out from the enable edge. Runs that differ only in the hold setting must then differ by exactly the hold length. Saturation cases start one or two steps from the rail and then watch for a long stretch to make sure no wrap or extra step occurs.

// File: rtl/alc_pkg.sv
// Shared types and constants for the level control loop.
// Assumes a target code of 4 bits, 1.5 dB per step from -28.5 dBFS.
package alc_pkg;

    typedef enum logic [1:0] {
        ZONE_BAND  = 2'd0,
        ZONE_QUIET = 2'd1,
        ZONE_LOUD  = 2'd2
    } zone_e;

    // Target level as a fraction of full scale, Q15 (full scale = 32768).
    function automatic logic [15:0] target_q15(input logic [3:0] code);
        logic [15:0] v;
        case (code)
            4'd0:    v = 16'd1231;
            4'd1:    v = 16'd1464;
            4'd2:    v = 16'd1740;
            4'd3:    v = 16'd2067;
            4'd4:    v = 16'd2457;
            4'd5:    v = 16'd2920;
            4'd6:    v = 16'd3471;
            4'd7:    v = 16'd4125;
            4'd8:    v = 16'd4903;
            4'd9:    v = 16'd5827;
            4'd10:   v = 16'd6925;
            4'd11:   v = 16'd8231;
            4'd12:   v = 16'd9782;
            4'd13:   v = 16'd11626;
            4'd14:   v = 16'd13818;
            default: v = 16'd16422;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/alc_peak_detect.sv
// Peak classifier: finds the magnitude of each strobed sample and sorts the
// signal into loud, quiet or band zones. A single loud sample flags loud
// at once; quiet and band are decided only at the end of a PEAK_WIN window.
// Assumes the samples are two's complement and SAMPLE_W >= 8.
module alc_peak_detect
    import alc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int PEAK_WIN = 8,
    parameter int HYST_SH  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [3:0]                 cfg_target,
    output zone_e                      zone
);

    localparam int WIN_W = (PEAK_WIN > 1) ? $clog2(PEAK_WIN) : 1;

    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] thr;
    logic [SAMPLE_W-1:0] thr_lo;
    logic [SAMPLE_W-1:0] peak_now;
    logic [SAMPLE_W-1:0] win_max;
    logic [WIN_W-1:0]    win_cnt;
    logic [15:0]         q15;

    // Sample magnitude; the most negative value maps to 2^(SAMPLE_W-1).
    assign mag = smp_data[SAMPLE_W-1] ? SAMPLE_W'(~smp_data + 1'b1) : SAMPLE_W'(smp_data);

    assign q15 = target_q15(cfg_target);

    // Scale the Q15 target fraction to the sample width.
    generate
        if (SAMPLE_W >= 16) begin : g_thr_wide
            assign thr = SAMPLE_W'(q15) << (SAMPLE_W - 16);
        end else begin : g_thr_narrow
            assign thr = SAMPLE_W'(q15 >> (16 - SAMPLE_W));
        end
    endgenerate

    // Lower edge of the hysteresis band.
    assign thr_lo = thr - (thr >> HYST_SH);

    // Running maximum including the current sample.
    assign peak_now = (mag > win_max) ? mag : win_max;

    // Window bookkeeping and zone decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            win_cnt <= '0;
            win_max <= '0;
            zone    <= ZONE_BAND;
        end else if (smp_valid) begin
            if (win_cnt == WIN_W'(PEAK_WIN - 1)) begin
                win_cnt <= '0;
                win_max <= '0;
                if (peak_now > thr)
                    zone <= ZONE_LOUD;
                else if (peak_now < thr_lo)
                    zone <= ZONE_QUIET;
                else
                    zone <= ZONE_BAND;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                win_max <= peak_now;
                if (mag > thr)
                    zone <= ZONE_LOUD;
            end
        end
    end

    // R3: a sample above threshold makes the zone loud next cycle.
    a_r3_loud_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_valid && (mag > thr)) |=> (zone == ZONE_LOUD) || !en);

    // R4: entering the quiet zone happens only at a window end.
    a_r4_quiet_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (zone == ZONE_QUIET) && ($past(zone) != ZONE_QUIET))
            |-> ($past(win_cnt) == WIN_W'(PEAK_WIN - 1)) && $past(smp_valid));

endmodule

// File: rtl/alc_gain_fsm.sv
// Gain update engine: counts ticks, applies the hold delay before raising
// the gain, steps the gain at the attack or decay interval and saturates
// at both rails. Assumes the zone input is registered.
module alc_gain_fsm
    import alc_pkg::*;
#(
    parameter int GAIN_W       = 6,
    parameter int TICK_DIV     = 256,
    parameter int HOLD_BASE    = 128,
    parameter int DEC_STEP_ALC = 20,
    parameter int ATK_STEP_ALC = 5,
    parameter int DEC_STEP_LIM = 4,
    parameter int ATK_STEP_LIM = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  zone_e             zone,
    input  logic [3:0]        cfg_hold,
    input  logic [3:0]        cfg_decay,
    input  logic [3:0]        cfg_attack,
    input  logic              cfg_limiter,
    input  logic [GAIN_W-1:0] cfg_manual_gain,
    output logic [GAIN_W-1:0] gain_q,
    output logic              busy
);

    localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PRE_W-1:0]  pre;
    logic              tick;
    logic [31:0]       hold_len, dec_int, atk_int;
    logic [31:0]       hold_cnt, step_cnt, hold_eff, step_eff;
    logic [31:0]       hold_n, step_n;
    logic [GAIN_W-1:0] gain_n;
    zone_e             last_zone;
    logic              zone_chg;

    assign tick     = (pre == PRE_W'(TICK_DIV - 1));
    assign hold_len = (cfg_hold == 4'd0) ? 32'd0 : (32'(HOLD_BASE) << (cfg_hold - 4'd1));
    assign dec_int  = (cfg_limiter ? 32'(DEC_STEP_LIM) : 32'(DEC_STEP_ALC)) << cfg_decay;
    assign atk_int  = (cfg_limiter ? 32'(ATK_STEP_LIM) : 32'(ATK_STEP_ALC)) << cfg_attack;

    // A zone change restarts both timers from zero in the same cycle.
    assign zone_chg = (zone != last_zone);
    assign hold_eff = zone_chg ? 32'd0 : hold_cnt;
    assign step_eff = zone_chg ? 32'd0 : step_cnt;

    // Next-state of timers and gain for one tick.
    always_comb begin
        hold_n = hold_eff;
        step_n = step_eff;
        gain_n = gain_q;
        if (zone == ZONE_BAND) begin
            hold_n = 32'd0;
            step_n = 32'd0;
        end else if (tick) begin
            if (zone == ZONE_LOUD) begin
                hold_n = 32'd0;
                if (step_eff == atk_int - 32'd1) begin
                    step_n = 32'd0;
                    if (gain_q != '0) gain_n = gain_q - GAIN_W'(1);
                end else begin
                    step_n = step_eff + 32'd1;
                end
            end else if (hold_eff < hold_len) begin
                hold_n = hold_eff + 32'd1;
            end else if (step_eff == dec_int - 32'd1) begin
                step_n = 32'd0;
                if (gain_q != GMAX) gain_n = gain_q + GAIN_W'(1);
            end else begin
                step_n = step_eff + 32'd1;
            end
        end
    end

    // State registers; disabled state tracks the manual gain.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre       <= '0;
            hold_cnt  <= 32'd0;
            step_cnt  <= 32'd0;
            last_zone <= ZONE_BAND;
            gain_q    <= cfg_manual_gain;
        end else begin
            pre       <= tick ? '0 : pre + 1'b1;
            hold_cnt  <= hold_n;
            step_cnt  <= step_n;
            last_zone <= zone;
            gain_q    <= gain_n;
        end
    end

    // Ramp activity flag.
    always_comb begin
        busy = en && (((zone == ZONE_LOUD) && (gain_q != '0)) ||
                      ((zone == ZONE_QUIET) && (hold_eff >= hold_len) && (gain_q != GMAX)));
    end

    // R1: at most one code step per cycle while enabled.
    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> ((gain_q == $past(gain_q)) ||
                               (gain_q == $past(gain_q) + GAIN_W'(1)) ||
                               (gain_q == $past(gain_q) - GAIN_W'(1))));

    // R9: no wrap from the bottom rail.
    a_r9_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($past(gain_q) == '0)) |-> (gain_q != GMAX));

    // R9: no wrap from the top rail.
    a_r9_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($past(gain_q) == GMAX)) |-> (gain_q != '0));

    // R5: a loud zone never raises the gain.
    a_r5_loud_never_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($past(zone) == ZONE_LOUD)) |-> (gain_q <= $past(gain_q)));

    // R11: the band zone holds the gain.
    a_r11_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($past(zone) == ZONE_BAND)) |-> (gain_q == $past(gain_q)));

    // R2: the loop starts from the manual gain when enabled.
    a_r2_start_manual: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (gain_q == $past(cfg_manual_gain)));

endmodule

// File: rtl/alc_gain_loop.sv
// Top of the automatic level control loop: peak classifier feeding the gain
// engine, with a manual bypass while disabled. Assumes one sample per strobe.
module alc_gain_loop #(
    parameter int SAMPLE_W     = 16,
    parameter int GAIN_W       = 6,
    parameter int PEAK_WIN     = 8,
    parameter int HYST_SH      = 3,
    parameter int TICK_DIV     = 256,
    parameter int HOLD_BASE    = 128,
    parameter int DEC_STEP_ALC = 20,
    parameter int ATK_STEP_ALC = 5,
    parameter int DEC_STEP_LIM = 4,
    parameter int ATK_STEP_LIM = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [3:0]                 cfg_target,
    input  logic [3:0]                 cfg_hold,
    input  logic [3:0]                 cfg_decay,
    input  logic [3:0]                 cfg_attack,
    input  logic                       cfg_limiter,
    input  logic [GAIN_W-1:0]          cfg_manual_gain,
    output logic [GAIN_W-1:0]          gain_code,
    output logic                       gain_busy
);

    alc_pkg::zone_e    zone;
    logic [GAIN_W-1:0] gain_q;

    alc_peak_detect #(
        .SAMPLE_W (SAMPLE_W),
        .PEAK_WIN (PEAK_WIN),
        .HYST_SH  (HYST_SH)
    ) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .cfg_target (cfg_target),
        .zone       (zone)
    );

    alc_gain_fsm #(
        .GAIN_W       (GAIN_W),
        .TICK_DIV     (TICK_DIV),
        .HOLD_BASE    (HOLD_BASE),
        .DEC_STEP_ALC (DEC_STEP_ALC),
        .ATK_STEP_ALC (ATK_STEP_ALC),
        .DEC_STEP_LIM (DEC_STEP_LIM),
        .ATK_STEP_LIM (ATK_STEP_LIM)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .zone            (zone),
        .cfg_hold        (cfg_hold),
        .cfg_decay       (cfg_decay),
        .cfg_attack      (cfg_attack),
        .cfg_limiter     (cfg_limiter),
        .cfg_manual_gain (cfg_manual_gain),
        .gain_q          (gain_q),
        .busy            (gain_busy)
    );

    // Manual bypass while the loop is off.
    assign gain_code = en ? gain_q : cfg_manual_gain;

endmodule

// File: tb/alc_gain_loop_tb.sv
// Scoreboard bench: run_case predicts each gain event (cycle stamp and code)
// into a queue, the monitor pops and compares on every observed change.
module alc_gain_loop_tb;

    localparam int W   = 16;
    localparam int WIN = 4;
    localparam int HB  = 8;
    localparam int DA  = 6;
    localparam int AA  = 3;
    localparam int DL  = 2;
    localparam int AL  = 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic [3:0]         cfg_target = 4'd15;
    logic [3:0]         cfg_hold = 4'd0;
    logic [3:0]         cfg_decay = 4'd0;
    logic [3:0]         cfg_attack = 4'd0;
    logic               cfg_limiter = 1'b0;
    logic [5:0]         cfg_manual_gain = 6'd17;
    logic [5:0]         gain_code;
    logic               gain_busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int    stamp;
        int    gain;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    alc_gain_loop #(
        .SAMPLE_W (W), .GAIN_W (6), .PEAK_WIN (WIN), .HYST_SH (3),
        .TICK_DIV (1), .HOLD_BASE (HB),
        .DEC_STEP_ALC (DA), .ATK_STEP_ALC (AA),
        .DEC_STEP_LIM (DL), .ATK_STEP_LIM (AL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .en (en),
        .smp_valid (smp_valid), .smp_data (smp_data),
        .cfg_target (cfg_target), .cfg_hold (cfg_hold),
        .cfg_decay (cfg_decay), .cfg_attack (cfg_attack),
        .cfg_limiter (cfg_limiter), .cfg_manual_gain (cfg_manual_gain),
        .gain_code (gain_code), .gain_busy (gain_busy)
    );

    // Monitor: pop and compare on every gain change while enabled.
    int last_g = 17;
    always @(posedge clk) begin
        #1;
        if (en && (int'(gain_code) != last_g)) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected gain change at cycle %0d: actual %0d, expected none (R5/R6/R9/R11)",
                         cyc, gain_code);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.stamp != cyc || e.gain != int'(gain_code)) begin
                    fails++;
                    $display("FAIL %s: actual gain %0d at cycle %0d, expected %0d at cycle %0d",
                             e.tag, gain_code, cyc, e.gain, e.stamp);
                end
            end
        end
        last_g = int'(gain_code);
    end

    task automatic check_val(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d, expected %0d", tag, act, expv);
        end
    endtask

    // Driver: predict the events for one case, then drive the samples.
    task automatic run_case(input int mg, input int amp, input int tgt, input int hold,
                            input int dec, input int atk, input int lim, input int nmax,
                            input int bn, input int bexp, input string tag);
        real thr;
        bit  loud, quiet, sat;
        int  g, n, step, last, stop, start, k, hl, sgn;
        @(negedge clk);
        en = 1'b0;
        smp_valid = 1'b0;
        cfg_manual_gain = 6'(mg);
        cfg_target = 4'(tgt);
        cfg_hold = 4'(hold);
        cfg_decay = 4'(dec);
        cfg_attack = 4'(atk);
        cfg_limiter = lim[0];
        repeat (2) @(negedge clk);
        thr   = 32768.0 * (10.0 ** ((-28.5 + 1.5 * tgt) / 20.0));
        loud  = (amp > thr);
        quiet = (amp < thr * 0.875);
        hl    = (hold == 0) ? 0 : (HB << (hold - 1));
        g = mg; n = 0; step = 1; sat = 0; k = 0;
        start = cyc;
        last  = start + 1;
        if (loud) begin
            step = (lim != 0 ? AL : AA) << atk;
            n = step;
        end else if (quiet) begin
            step = (lim != 0 ? DL : DA) << dec;
            n = WIN - 1 + hl + step;
        end
        if (loud || quiet) begin
            while (k < nmax) begin
                if ((loud && g == 0) || (quiet && g == 63)) begin
                    sat = 1;
                    break;
                end
                g = loud ? g - 1 : g + 1;
                exp_q.push_back('{start + 1 + n, g, tag});
                last = start + 1 + n;
                n += step;
                k++;
            end
        end
        stop = (sat || !(loud || quiet)) ? last + 40 : last + step - 1;
        en = 1'b1;
        smp_valid = 1'b1;
        smp_data = W'(amp);
        sgn = 1;
        while (cyc < stop) begin
            @(negedge clk);
            sgn = -sgn;
            smp_data = W'(sgn * amp);
            if (bn >= 0 && cyc == start + 1 + bn)
                check_val({tag, " R10 busy"}, int'(gain_busy), bexp);
        end
        en = 1'b0;
        smp_valid = 1'b0;
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d events missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_val("R2 reset manual", int'(gain_code), 17);
        check_val("R2 reset busy", int'(gain_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_manual_gain = 6'd33;
        #0;
        check_val("R2 manual follow", int'(gain_code), 33);
        // R5 R3: loud ALC attack, hold setting must not delay it.
        run_case(40, 20000, 15, 5, 0, 0, 0, 4, 4, 1, "R5 loud attack");
        // R7: attack setting doubles the interval twice.
        run_case(40, 20000, 15, 0, 0, 2, 0, 3, -1, 0, "R7 attack shift");
        // R4 R6: quiet, no hold.
        run_case(20, 5000, 15, 0, 0, 0, 0, 3, 12, 1, "R6 quiet no hold");
        // R6: hold of 16 ticks, busy low during hold.
        run_case(20, 5000, 15, 2, 0, 0, 0, 2, 10, 0, "R6 quiet hold");
        // R7: decay setting 1.
        run_case(20, 5000, 15, 0, 1, 0, 0, 2, -1, 0, "R7 decay shift");
        // R8: limiter bases.
        run_case(10, 20000, 15, 0, 0, 0, 1, 3, -1, 0, "R8 limiter attack");
        run_case(10, 5000, 15, 0, 0, 0, 1, 3, -1, 0, "R8 limiter decay");
        // R9: saturation at both rails.
        run_case(2, 20000, 15, 0, 0, 0, 1, 10, 20, 0, "R9 floor");
        run_case(62, 5000, 15, 0, 0, 0, 1, 10, 20, 0, "R9 ceiling");
        // R11: band zone holds.
        run_case(30, 15500, 15, 0, 0, 0, 1, 5, 30, 0, "R11 band");
        // R3: low target makes a small signal loud; full-negative sample.
        run_case(30, 3000, 0, 0, 0, 0, 0, 2, -1, 0, "R3 low target");
        run_case(30, 32768, 15, 0, 0, 0, 0, 2, -1, 0, "R3 most negative");
        @(negedge clk);
        cfg_manual_gain = 6'd9;
        #0;
        check_val("R2 manual after run", int'(gain_code), 9);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule